// File: doc/BRIEF.md
# EEPROM Write-Lock Sequence Controller

This block sits between a parallel byte-write bus and the program engine of an EEPROM array. For every write cycle it decides whether the byte may be programmed. When a write is allowed, it issues a one-cycle start strobe and holds the write's address and data for the engine. It then stays busy for a programmable number of cycles, which stands in for the array's program time.

A software write lock guards the array. A three-write unlock prefix, followed by one ordinary data write, turns the lock on. That fourth write both programs its byte and sets the lock. While the lock is on, a lone write is discarded. Repeating the prefix lets exactly one following write through. A separate six-write code clears the lock.

An active-low guard input works like a hardware reset of the write path. While it is low, no write is accepted. Pulling it low during a program aborts the program. After it returns high, writes stay blocked for a recovery window. The lock bit behaves as a non-volatile bit: only the power-on reset and the six-write code clear it.

Top module: `eeprom_wlock_ctrl`

## Requirements
- R1: With the lock off, an accepted write whose address and data match no sequence step raises `pgm_start` at the next clock edge. On that edge it latches the write's address into `pgm_addr` and its data into `pgm_data`.
- R2: The writes 5555h/AAh, then AAAAh or 2AAAh with 55h, then 5555h/A0h, followed by any fourth write, program that fourth write. The fourth write also sets `protect_on`, in the same cycle that `pgm_start` rises.
- R3: The three prefix writes never program. The prefix alone leaves `protect_on` unchanged.
- R4: While `protect_on` is 1, a write that does not follow a complete prefix is discarded and raises no `pgm_start`. A write that does follow a complete prefix is programmed.
- R5: The writes 5555h/AAh, AAAAh-or-2AAAh/55h, 5555h/80h, 5555h/AAh, AAAAh-or-2AAAh/55h, 5555h/20h clear `protect_on` at the edge of the sixth write. None of these six writes programs.
- R6: A write that does not match the expected next step returns the tracker to its first step. That write is then handled as an ordinary write: programmed if the lock is off, discarded if it is on.
- R7: `protect_on` is 0 after the power-on reset. The guard input never changes it.
- R8: While `guard_n` is 0, no write is accepted. The tracker returns to its first step.
- R9: If `guard_n` is 0 while `busy` is 1, `busy` is 0 after the next clock edge (abort).
- R10: After `guard_n` returns to 1, and after power-on reset, writes at the first RECOVER_CYCLES clock edges are ignored.
- R11: After `pgm_start`, `busy` stays 1 for exactly PROG_CYCLES cycles. Writes made while busy are ignored: no start, no tracker change, and the latched address is kept.
- R12: `pgm_start` is a single-cycle pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Active-low power-on reset; clears all state including the lock |
| guard_n | input | 1 | Active-low write guard; low blocks writes and aborts a program |
| wr_valid | input | 1 | One write cycle is present this clock |
| wr_addr | input | AW | Write address |
| wr_data | input | DW | Write data |
| pgm_start | output | 1 | One-cycle program-start strobe |
| pgm_addr | output | AW | Address of the byte being programmed |
| pgm_data | output | DW | Data of the byte being programmed |
| protect_on | output | 1 | Write lock is active |
| busy | output | 1 | A program operation is running |

## Verification
The assertions assume that `guard_n` is already synchronous to `clk`. They also assume a write cycle lasts one clock with `wr_valid` high and never overlaps a change of the guard. The recovery check assumes RECOVER_CYCLES is at least one.

The bench drives every input at the falling edge and changes `guard_n` only between write cycles. It waits for `busy` to drop before each write, except where a write made during a program is the point of the test.

// File: rtl/wlk_pkg.sv
`timescale 1ns/1ps
package wlk_pkg;

  typedef enum logic [2:0] {
    TRK_IDLE,
    TRK_KEY1,
    TRK_KEY2,
    TRK_ARMED,
    TRK_OFF3,
    TRK_OFF4,
    TRK_OFF5
  } trk_state_t;

  typedef struct packed {
    logic prog;
    logic set_lock;
    logic clr_lock;
  } wr_verdict_t;

  // Next value of a down-counter that reloads on load and stops at zero.
  function automatic int unsigned tick_down(input int unsigned cur,
                                            input logic load,
                                            input int unsigned reload);
    if (load) return reload;
    if (cur != 0) return cur - 1;
    return 0;
  endfunction

endpackage

// File: rtl/wlk_seq.sv
`timescale 1ns/1ps
module wlk_seq
  import wlk_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 8,
  parameter logic [AW-1:0] LEAD_ADDR  = 16'h5555,
  parameter logic [AW-1:0] MID_ADDR_A = 16'hAAAA,
  parameter logic [AW-1:0] MID_ADDR_B = 16'h2AAA,
  parameter logic [DW-1:0] KEY1       = 8'hAA,
  parameter logic [DW-1:0] KEY2       = 8'h55,
  parameter logic [DW-1:0] ON_CODE    = 8'hA0,
  parameter logic [DW-1:0] OFF_CODE   = 8'h80,
  parameter logic [DW-1:0] KILL_CODE  = 8'h20
) (
  input  logic          clk,
  input  logic          por_n,
  input  logic          guard_n,
  input  logic          accept,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] data,
  output wr_verdict_t   verdict,
  output logic          protect_on
);

  trk_state_t st_q, st_d;
  logic       lock_q;

  function automatic logic lead_hit(input logic [AW-1:0] a,
                                    input logic [DW-1:0] d,
                                    input logic [DW-1:0] code);
    return (a == LEAD_ADDR) && (d == code);
  endfunction

  function automatic logic mid_hit(input logic [AW-1:0] a,
                                   input logic [DW-1:0] d);
    return ((a == MID_ADDR_A) || (a == MID_ADDR_B)) && (d == KEY2);
  endfunction

  always_comb begin
    st_d             = TRK_IDLE;
    verdict.prog     = !lock_q;
    verdict.set_lock = 1'b0;
    verdict.clr_lock = 1'b0;
    unique case (st_q)
      TRK_IDLE:
        if (lead_hit(addr, data, KEY1)) begin
          st_d = TRK_KEY1; verdict.prog = 1'b0;
        end
      TRK_KEY1:
        if (mid_hit(addr, data)) begin
          st_d = TRK_KEY2; verdict.prog = 1'b0;
        end
      TRK_KEY2:
        if (lead_hit(addr, data, ON_CODE)) begin
          st_d = TRK_ARMED; verdict.prog = 1'b0;
        end else if (lead_hit(addr, data, OFF_CODE)) begin
          st_d = TRK_OFF3; verdict.prog = 1'b0;
        end
      TRK_ARMED: begin
        verdict.prog     = 1'b1;
        verdict.set_lock = 1'b1;
      end
      TRK_OFF3:
        if (lead_hit(addr, data, KEY1)) begin
          st_d = TRK_OFF4; verdict.prog = 1'b0;
        end
      TRK_OFF4:
        if (mid_hit(addr, data)) begin
          st_d = TRK_OFF5; verdict.prog = 1'b0;
        end
      TRK_OFF5:
        if (lead_hit(addr, data, KILL_CODE)) begin
          verdict.prog     = 1'b0;
          verdict.clr_lock = 1'b1;
        end
      default: st_d = TRK_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!por_n) begin
      st_q   <= TRK_IDLE;
      lock_q <= 1'b0;
    end else if (!guard_n) begin
      st_q <= TRK_IDLE;
    end else if (accept) begin
      st_q <= st_d;
      if (verdict.set_lock)      lock_q <= 1'b1;
      else if (verdict.clr_lock) lock_q <= 1'b0;
    end
  end

  assign protect_on = lock_q;

endmodule

// File: rtl/wlk_busy.sv
`timescale 1ns/1ps
module wlk_busy
  import wlk_pkg::*;
#(
  parameter int PROG_CYCLES = 1250000
) (
  input  logic clk,
  input  logic por_n,
  input  logic start,
  input  logic abort,
  output logic busy
);

  localparam int CW = $clog2(PROG_CYCLES + 1);

  logic [CW-1:0] left_q;
  logic          busy_q;

  always_ff @(posedge clk) begin
    if (!por_n) begin
      busy_q <= 1'b0;
      left_q <= '0;
    end else if (abort) begin
      busy_q <= 1'b0;
      left_q <= '0;
    end else if (start) begin
      busy_q <= 1'b1;
      left_q <= CW'(tick_down(0, 1'b1, PROG_CYCLES - 1));
    end else if (busy_q) begin
      if (left_q == '0) busy_q <= 1'b0;
      left_q <= CW'(tick_down(int'(left_q), 1'b0, 0));
    end
  end

  assign busy = busy_q;

endmodule

// File: rtl/wlk_recover.sv
`timescale 1ns/1ps
module wlk_recover
  import wlk_pkg::*;
#(
  parameter int RECOVER_CYCLES = 12500
) (
  input  logic clk,
  input  logic por_n,
  input  logic guard_n,
  output logic ready
);

  localparam int RW = $clog2(RECOVER_CYCLES + 1);

  logic [RW-1:0] wait_q;

  always_ff @(posedge clk) begin
    if (!por_n) wait_q <= RW'(RECOVER_CYCLES);
    else        wait_q <= RW'(tick_down(int'(wait_q), !guard_n, RECOVER_CYCLES));
  end

  assign ready = guard_n && (wait_q == '0);

endmodule

// File: rtl/eeprom_wlock_ctrl.sv
`timescale 1ns/1ps
module eeprom_wlock_ctrl
  import wlk_pkg::*;
#(
  parameter int AW             = 16,
  parameter int DW             = 8,
  parameter int PROG_CYCLES    = 1250000,
  parameter int RECOVER_CYCLES = 12500
) (
  input  logic          clk,
  input  logic          por_n,
  input  logic          guard_n,
  input  logic          wr_valid,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  output logic          pgm_start,
  output logic [AW-1:0] pgm_addr,
  output logic [DW-1:0] pgm_data,
  output logic          protect_on,
  output logic          busy
);

  wr_verdict_t verdict;
  logic        ready;
  logic        accept;
  logic        start_evt;
  logic        abort_evt;

  assign accept    = wr_valid && ready && !busy;
  assign start_evt = accept && verdict.prog;
  assign abort_evt = busy && !guard_n;

  wlk_seq #(.AW(AW), .DW(DW)) u_seq (
    .clk(clk), .por_n(por_n), .guard_n(guard_n), .accept(accept),
    .addr(wr_addr), .data(wr_data), .verdict(verdict), .protect_on(protect_on)
  );

  wlk_busy #(.PROG_CYCLES(PROG_CYCLES)) u_busy (
    .clk(clk), .por_n(por_n), .start(start_evt), .abort(abort_evt), .busy(busy)
  );

  wlk_recover #(.RECOVER_CYCLES(RECOVER_CYCLES)) u_recover (
    .clk(clk), .por_n(por_n), .guard_n(guard_n), .ready(ready)
  );

  always_ff @(posedge clk) begin
    if (!por_n) begin
      pgm_start <= 1'b0;
      pgm_addr  <= '0;
      pgm_data  <= '0;
    end else begin
      pgm_start <= start_evt;
      if (start_evt) begin
        pgm_addr <= wr_addr;
        pgm_data <= wr_data;
      end
    end
  end

endmodule

module wlk_ctrl_chk (
  input logic clk,
  input logic por_n,
  input logic guard_n,
  input logic pgm_start,
  input logic busy,
  input logic protect_on,
  input logic start_evt,
  input logic abort_evt
);

  assert_start_guarded_R8: assert property (@(posedge clk) disable iff (!por_n)
    pgm_start |-> $past(guard_n));

  assert_abort_drops_busy_R9: assert property (@(posedge clk) disable iff (!por_n)
    abort_evt |=> !busy);

  assert_recover_block_R10: assert property (@(posedge clk) disable iff (!por_n)
    $rose(guard_n) |=> !pgm_start);

  assert_no_start_while_busy_R11: assert property (@(posedge clk) disable iff (!por_n)
    pgm_start |-> !$past(busy));

  assert_start_sets_busy_R11: assert property (@(posedge clk) disable iff (!por_n)
    start_evt |=> (pgm_start && busy));

  assert_lock_rise_with_start_R2: assert property (@(posedge clk) disable iff (!por_n)
    $rose(protect_on) |-> pgm_start);

  assert_lock_fall_no_start_R5: assert property (@(posedge clk) disable iff (!por_n)
    $fell(protect_on) |-> !pgm_start);

  assert_lock_guard_free_R7: assert property (@(posedge clk) disable iff (!por_n)
    !guard_n |=> $stable(protect_on));

  assert_single_pulse_R12: assert property (@(posedge clk) disable iff (!por_n)
    pgm_start |=> !pgm_start);

endmodule

bind eeprom_wlock_ctrl wlk_ctrl_chk u_chk (
  .clk(clk), .por_n(por_n), .guard_n(guard_n), .pgm_start(pgm_start),
  .busy(busy), .protect_on(protect_on), .start_evt(start_evt),
  .abort_evt(abort_evt)
);

// File: tb/eeprom_wlock_ctrl_tb.sv
`timescale 1ns/1ps
module eeprom_wlock_ctrl_tb;

  localparam int PCY = 8;
  localparam int RCY = 4;

  logic        clk = 1'b0;
  logic        por_n = 1'b0;
  logic        guard_n = 1'b1;
  logic        wr_valid = 1'b0;
  logic [15:0] wr_addr = '0;
  logic [7:0]  wr_data = '0;
  logic        pgm_start, protect_on, busy;
  logic [15:0] pgm_addr;
  logic [7:0]  pgm_data;

  int total = 0;
  int bad = 0;

  always #4 clk = ~clk;

  eeprom_wlock_ctrl #(.AW(16), .DW(8), .PROG_CYCLES(PCY), .RECOVER_CYCLES(RCY)) u_dut (
    .clk(clk), .por_n(por_n), .guard_n(guard_n), .wr_valid(wr_valid),
    .wr_addr(wr_addr), .wr_data(wr_data), .pgm_start(pgm_start),
    .pgm_addr(pgm_addr), .pgm_data(pgm_data), .protect_on(protect_on), .busy(busy)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic settle();
    while (busy) @(negedge clk);
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d, output bit st);
    @(negedge clk);
    wr_valid = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_valid = 1'b0;
    st = pgm_start;
  endtask

  task automatic guard_pulse();
    @(negedge clk); guard_n = 1'b0;
    @(negedge clk); guard_n = 1'b1;
    repeat (RCY + 1) @(negedge clk);
  endtask

  task automatic t_reset();
    chk(pgm_start == 0, "R12", "start after reset", pgm_start, 0);
    chk(busy == 0, "R11", "busy after reset", busy, 0);
    chk(protect_on == 0, "R7", "lock after reset", protect_on, 0);
  endtask

  task automatic t_plain();
    bit st; int n;
    wr(16'h1234, 8'h5A, st);
    chk(st, "R1", "plain write start", st, 1);
    chk(pgm_addr == 16'h1234, "R1", "latched addr", pgm_addr, 16'h1234);
    chk(pgm_data == 8'h5A, "R1", "latched data", pgm_data, 8'h5A);
    n = 0;
    while (busy) begin
      n++;
      if (n == 2) chk(pgm_start == 0, "R12", "start pulse width", pgm_start, 0);
      @(negedge clk);
    end
    chk(n == PCY, "R11", "busy length", n, PCY);
  endtask

  task automatic t_prefix_only();
    bit s1, s2, s3, s4;
    wr(16'h5555, 8'hAA, s1);
    wr(16'hAAAA, 8'h55, s2);
    wr(16'h5555, 8'hA0, s3);
    chk({s1, s2, s3} == 3'b000, "R3", "prefix writes program", {s1, s2, s3}, 0);
    chk(protect_on == 0, "R3", "lock after prefix only", protect_on, 0);
    guard_pulse();
    wr(16'h0042, 8'h99, s4);
    settle();
    chk(s4, "R8", "write after guard clears tracker", s4, 1);
    chk(protect_on == 0, "R8", "no arming after guard", protect_on, 0);
  endtask

  task automatic t_mismatch_open();
    bit s1, s2, s3;
    wr(16'h5555, 8'hAA, s1);
    wr(16'h3333, 8'h77, s2);
    settle();
    chk(!s1 && s2, "R6", "mismatch programs when open", s2, 1);
    chk(pgm_addr == 16'h3333, "R6", "mismatch address", pgm_addr, 16'h3333);
    wr(16'h2AAA, 8'h55, s3);
    settle();
    chk(s3, "R6", "tracker restarted", s3, 1);
  endtask

  task automatic t_enable();
    bit s1, s2, s3, s4;
    wr(16'h5555, 8'hAA, s1);
    wr(16'h2AAA, 8'h55, s2);
    wr(16'h5555, 8'hA0, s3);
    wr(16'h0777, 8'hC3, s4);
    chk({s1, s2, s3} == 3'b000, "R3", "prefix no program", {s1, s2, s3}, 0);
    chk(s4, "R2", "fourth write programs", s4, 1);
    chk(protect_on == 1, "R2", "lock set with start", protect_on, 1);
    chk(pgm_data == 8'hC3, "R2", "fourth write data", pgm_data, 8'hC3);
    settle();
  endtask

  task automatic t_locked();
    bit s1, s2, s3, s4;
    wr(16'h0100, 8'h01, s1);
    chk(!s1, "R4", "locked lone write", s1, 0);
    wr(16'h5555, 8'hAA, s2);
    wr(16'h1111, 8'h55, s3);
    wr(16'h5555, 8'hA0, s4);
    chk(!s3 && !s4, "R6", "mismatch discarded when locked", {s3, s4}, 0);
    guard_pulse();
    chk(protect_on == 1, "R7", "lock kept across guard", protect_on, 1);
    wr(16'h5555, 8'hAA, s1);
    wr(16'hAAAA, 8'h55, s2);
    wr(16'h5555, 8'hA0, s3);
    wr(16'h0200, 8'h3C, s4);
    chk(s4 && pgm_addr == 16'h0200, "R4", "write after prefix while locked", pgm_addr, 16'h0200);
    settle();
  endtask

  task automatic t_disable();
    bit s[6];
    wr(16'h5555, 8'hAA, s[0]);
    wr(16'hAAAA, 8'h55, s[1]);
    wr(16'h5555, 8'h80, s[2]);
    wr(16'h5555, 8'hAA, s[3]);
    wr(16'h2AAA, 8'h55, s[4]);
    wr(16'h5555, 8'h20, s[5]);
    for (int i = 0; i < 6; i++) chk(!s[i], "R5", "disable step programs", s[i], 0);
    chk(protect_on == 0, "R5", "lock cleared", protect_on, 1'b0);
    wr(16'h0300, 8'h44, s[0]);
    settle();
    chk(s[0], "R1", "write after unlock", s[0], 1);
  endtask

  task automatic t_busy_ignore();
    bit s1, s2;
    wr(16'h0400, 8'h11, s1);
    wr(16'h0500, 8'h22, s2);
    chk(s1 && !s2, "R11", "write during busy", s2, 0);
    settle();
    chk(pgm_addr == 16'h0400, "R11", "latched addr kept", pgm_addr, 16'h0400);
  endtask

  task automatic t_abort();
    bit s1;
    wr(16'h0600, 8'h66, s1);
    @(negedge clk);
    guard_n = 1'b0;
    @(negedge clk);
    chk(busy == 0, "R9", "busy after abort", busy, 0);
    guard_n = 1'b1;
    repeat (RCY + 1) @(negedge clk);
  endtask

  task automatic t_recover();
    bit s1, s2, s3;
    @(negedge clk); guard_n = 1'b0;
    wr(16'h0700, 8'h77, s1);
    chk(!s1, "R8", "write while guard low", s1, 0);
    guard_n = 1'b1;
    wr(16'h0701, 8'h78, s2);
    chk(!s2, "R10", "write inside recovery", s2, 0);
    repeat (RCY + 1) @(negedge clk);
    wr(16'h0702, 8'h79, s3);
    settle();
    chk(s3, "R10", "write after recovery", s3, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    por_n = 1'b1;
    @(negedge clk);
    t_reset();
    repeat (RCY + 2) @(negedge clk);
    t_plain();
    t_prefix_only();
    t_mismatch_open();
    t_enable();
    t_locked();
    t_disable();
    t_busy_ignore();
    t_abort();
    t_recover();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule